// File: doc/BRIEF.md
# Address Modifier Access Filter

This block decides whether a bus cycle arriving at the slave port may reach the onboard DRAM, judging only by the 6-bit address modifier that the remote master presents. Software holds an 8-bit enable register. Its bits fall into three groups. The first group selects the cycle kinds that are allowed: data, program or block. The second group selects the address spaces that are allowed: short, standard or extended. The third group selects the privilege levels that are allowed: user or supervisor.

The block sorts each modifier into one kind, one space and one privilege level. It accepts the modifier only when the enable bit for each of the three is set. If any group has no bit set, nothing is accepted. A modifier that the block does not recognise is never accepted.

The verdict is registered and goes to the slave controller, which combines it with its own address range decode. Software writes the register through a single-cycle write strobe and reads it back through a read-data port.

Top module: `am_access_filter`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `cfg_rdata_o` reads 0x00 and `match_o` is 0. With this value no modifier is accepted until software writes the register.
- R2: When `cfg_we_i` is high at a rising clock edge, all 8 bits of `cfg_wdata_i` are stored and appear on `cfg_rdata_o` after that edge. When `cfg_we_i` is low, the stored value does not change.
- R3: The register bits have fixed positions. Bit 0 enables data cycles, bit 1 program cycles and bit 2 block cycles. Bit 3 enables short space, bit 4 standard space and bit 5 extended space. Bit 6 enables user privilege and bit 7 supervisor privilege. A recognised modifier matches only when the bits for its kind, its space and its privilege are all set.
- R4: If bits 2:0 are all 0, or bits 5:3 are all 0, or bits 7:6 are all 0, no modifier produces a match.
- R5: The block decodes the standard-space modifiers as follows. 0x39, 0x3A and 0x3B are user data, user program and user block. 0x3D, 0x3E and 0x3F are supervisor data, supervisor program and supervisor block.
- R6: The block decodes the extended-space modifiers as follows. 0x09, 0x0A and 0x0B are user data, user program and user block. 0x0D, 0x0E and 0x0F are supervisor data, supervisor program and supervisor block.
- R7: The short-space modifiers are 0x29 (user) and 0x2D (supervisor). Both count as data cycles.
- R8: Every other 6-bit code never produces a match, even when the register holds 0xFF. This includes 0x0C.
- R9: `match_o` gives the verdict for the `am_i` value sampled at the previous rising edge. That verdict uses the register value held before that edge, so a write at the same edge takes effect only from the following sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| am_i | input | 6 | Address modifier of the incoming cycle |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Current register value |
| match_o | output | 1 | Registered access verdict |

## Verification
The verdict on `match_o` is due one rising edge after `am_i` is presented. The driver therefore changes `am_i` on a falling edge and pushes the expected verdict. The monitor pops that verdict 2 ns after the next rising edge. The expected value is computed from the register value the bench modelled at the moment of the push, so a write and a modifier that share an edge are judged with the old value.

Register readback is due right after the write edge and is checked on the following falling edge. The sweep covers every register value against every modifier code, so the empty-group rule and the unknown-code rule are exercised under every configuration.

// File: rtl/am_filter_pkg.sv
package am_filter_pkg;
  localparam int AM_W    = 6;
  localparam int KIND_W  = 3;
  localparam int SPACE_W = 3;
  localparam int PRIV_W  = 2;
  localparam int CFG_W   = KIND_W + SPACE_W + PRIV_W;
  localparam int KIND_LSB  = 0;
  localparam int SPACE_LSB = KIND_LSB + KIND_W;
  localparam int PRIV_LSB  = SPACE_LSB + SPACE_W;

  // one-hot classification, bit order matches the register groups
  typedef struct packed {
    logic               known;
    logic [PRIV_W-1:0]  priv;   // [0] user, [1] supervisor
    logic [SPACE_W-1:0] space;  // [0] short, [1] standard, [2] extended
    logic [KIND_W-1:0]  kind;   // [0] data, [1] program, [2] block
  } am_class_t;
endpackage

// File: rtl/am_classify.sv
module am_classify
  import am_filter_pkg::*;
(
  input  logic [AM_W-1:0] am_i,
  output am_class_t       cls_o
);
  logic [KIND_W-1:0]  kind;
  logic [SPACE_W-1:0] space;

  always_comb begin
    kind  = '0;
    space = '0;
    unique case (am_i[1:0])
      2'b01:   kind = 3'b001;
      2'b10:   kind = 3'b010;
      2'b11:   kind = 3'b100;
      default: kind = 3'b000;
    endcase
    unique case (am_i[5:3])
      3'b111:  space = 3'b010;
      3'b001:  space = 3'b100;
      3'b101:  space = (am_i[1:0] == 2'b01) ? 3'b001 : 3'b000;
      default: space = 3'b000;
    endcase
  end

  always_comb begin
    cls_o.known = (|kind) && (|space);
    cls_o.kind  = cls_o.known ? kind  : '0;
    cls_o.space = cls_o.known ? space : '0;
    cls_o.priv  = cls_o.known ? (am_i[2] ? 2'b10 : 2'b01) : '0;
  end
endmodule

// File: rtl/am_cfg_reg.sv
module am_cfg_reg
  import am_filter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= wdata_i;
  end

  assign cfg_o = cfg_q;

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cfg_q == $past(wdata_i)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_q));
endmodule

// File: rtl/am_match_stage.sv
module am_match_stage
  import am_filter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  am_class_t        cls_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             match_o
);
  logic [KIND_W-1:0]  en_kind;
  logic [SPACE_W-1:0] en_space;
  logic [PRIV_W-1:0]  en_priv;
  logic               hit_d, match_q;

  assign en_kind  = cfg_i[KIND_LSB  +: KIND_W];
  assign en_space = cfg_i[SPACE_LSB +: SPACE_W];
  assign en_priv  = cfg_i[PRIV_LSB  +: PRIV_W];

  assign hit_d = cls_i.known && (|(en_kind & cls_i.kind))
              && (|(en_space & cls_i.space)) && (|(en_priv & cls_i.priv));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= hit_d;
  end

  assign match_o = match_q;

  p_empty_group_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_kind == '0 || en_space == '0 || en_priv == '0) |=> !match_q);
  p_unknown_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cls_i.known |=> !match_q);
  p_class_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_i.known |-> ($countones(cls_i.kind) == 1 && $countones(cls_i.space) == 1
                     && $countones(cls_i.priv) == 1));
  p_short_is_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls_i.space[0] |-> cls_i.kind[0]);
endmodule

// File: rtl/am_access_filter.sv
module am_access_filter
  import am_filter_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AM_W-1:0]  am_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             match_o
);
  am_class_t        cls;
  logic [CFG_W-1:0] cfg;

  am_classify u_classify (
    .am_i  (am_i),
    .cls_o (cls)
  );

  am_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  am_match_stage u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cls_i   (cls),
    .cfg_i   (cfg),
    .match_o (match_o)
  );

  assign cfg_rdata_o = cfg;

  p_match_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> ($past(cfg) != '0));
endmodule

// File: tb/am_access_filter_tb.sv
module am_access_filter_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] am_i = '0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_rdata_o;
  logic       match_o;

  typedef struct {
    logic       exp;
    logic [5:0] am;
    string      tag;
  } item_t;

  item_t      sb_q[$];
  int         checks = 0;
  int         errors = 0;
  logic [7:0] model_cfg = '0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  am_access_filter u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .am_i        (am_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .match_o     (match_o)
  );

  // bit indices of kind / space / privilege for each recognised code, -1 if unknown
  function automatic void lookup(input logic [5:0] a, output int t, output int s, output int p);
    t = -1; s = -1; p = -1;
    case (a)
      6'h39: begin t = 0; s = 4; p = 6; end
      6'h3A: begin t = 1; s = 4; p = 6; end
      6'h3B: begin t = 2; s = 4; p = 6; end
      6'h3D: begin t = 0; s = 4; p = 7; end
      6'h3E: begin t = 1; s = 4; p = 7; end
      6'h3F: begin t = 2; s = 4; p = 7; end
      6'h09: begin t = 0; s = 5; p = 6; end
      6'h0A: begin t = 1; s = 5; p = 6; end
      6'h0B: begin t = 2; s = 5; p = 6; end
      6'h0D: begin t = 0; s = 5; p = 7; end
      6'h0E: begin t = 1; s = 5; p = 7; end
      6'h0F: begin t = 2; s = 5; p = 7; end
      6'h29: begin t = 0; s = 3; p = 6; end
      6'h2D: begin t = 0; s = 3; p = 7; end
      default: ;
    endcase
  endfunction

  function automatic logic model(input logic [5:0] a, input logic [7:0] c);
    int t, s, p;
    lookup(a, t, s, p);
    if (t < 0) return 1'b0;
    return c[t] & c[s] & c[p];
  endfunction

  function automatic string pick_tag(input logic [5:0] a, input logic [7:0] c);
    int t, s, p;
    lookup(a, t, s, p);
    if (t < 0) return "R8";
    if (c[2:0] == 0 || c[5:3] == 0 || c[7:6] == 0) return "R4";
    if (s == 4) return "R5";
    if (s == 5) return "R6";
    return "R7";
  endfunction

  task automatic drive_am(input logic [5:0] a, input string tag);
    item_t it;
    @(negedge clk_i);
    am_i   = a;
    it.exp = model(a, model_cfg);
    it.am  = a;
    it.tag = (tag == "") ? pick_tag(a, model_cfg) : tag;
    sb_q.push_back(it);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = v;
    am_i        = 6'h00;
    @(negedge clk_i);
    cfg_we_i  = 1'b0;
    model_cfg = v;
    checks++;
    if (cfg_rdata_o !== v) begin
      errors++;
      $display("FAIL R2 readback: actual %h expected %h", cfg_rdata_o, v);
    end
  endtask

  // R9: write and modifier share one edge, old value applies
  task automatic write_with_am(input logic [7:0] v, input logic [5:0] a);
    item_t it;
    @(negedge clk_i);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = v;
    am_i        = a;
    it.exp = model(a, model_cfg);
    it.am  = a;
    it.tag = "R9";
    sb_q.push_back(it);
    @(negedge clk_i);
    cfg_we_i  = 1'b0;
    model_cfg = v;
    #1;
    am_i = 6'h00;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (match_o !== it.exp) begin
          errors++;
          $display("FAIL %s am=%h cfg=%h: actual %b expected %b",
                   it.tag, it.am, model_cfg, match_o, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (cfg_rdata_o !== 8'h00) begin
      errors++;
      $display("FAIL R1 cfg after reset: actual %h expected 00", cfg_rdata_o);
    end
    checks++;
    if (match_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 match after reset: actual %b expected 0", match_o);
    end
    // R1: reset value accepts nothing
    drive_am(6'h39, "R1");
    drive_am(6'h3D, "R1");

    // R3: data + standard + user only
    write_cfg(8'b0101_0001);
    drive_am(6'h39, "R3");
    drive_am(6'h3A, "R3");
    drive_am(6'h3D, "R3");
    drive_am(6'h09, "R3");
    drive_am(6'h29, "R3");
    // R3: program + extended + supervisor only
    write_cfg(8'b1010_0010);
    drive_am(6'h0E, "R3");
    drive_am(6'h0A, "R3");
    drive_am(6'h3E, "R3");

    // R9: same-edge write uses the old register value
    write_with_am(8'hFF, 6'h39);
    drive_am(6'h39, "R9");
    write_with_am(8'h00, 6'h3F);
    drive_am(6'h3F, "R9");

    // R2 R4 R5 R6 R7 R8: every register value against every code
    for (int c = 0; c < 256; c++) begin
      write_cfg(c[7:0]);
      for (int a = 0; a < 64; a++) drive_am(a[5:0], "");
    end

    // R2: register holds without write strobe
    @(negedge clk_i);
    cfg_wdata_i = 8'h5A;
    @(negedge clk_i);
    checks++;
    if (cfg_rdata_o !== model_cfg) begin
      errors++;
      $display("FAIL R2 hold: actual %h expected %h", cfg_rdata_o, model_cfg);
    end

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule